// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block collects level-sensitive interrupt requests, qualifies each one against software-written enable state, and drives one interrupt line toward the CPU together with the vector of the winning request. Software never does a read-modify-write on the enable state. Each register has two word addresses. Writing the set address turns on the written ones. Writing the clear address turns off the written ones. Concurrent agents can therefore flip individual enables without racing.

Every source is gated by more than one enable field. One field is a bit in the mask register. The other is a multi-bit field in a priority register, and it counts as on when it is nonzero. Two kinds of source exist. The first kind are line sources, driven by individual request inputs. The second kind are chain sources, selected by a 4-bit encoded level input. All chain sources share one group field in the priority registers, so a single field change reaches every member of the group. Vector codes are fixed at build time as a base plus a per-source stride.

Top module: `setclr_intc`

## Requirements
- R1: A write to a set address (even word address 2r, with r=0 the mask register, r=1 the first priority register and r=2 the second) ORs the write data into register r. The mask register keeps only its low NUM_LINE+CHAIN_LEN bits, and its upper bits always read as zero.
- R2: A write to a clear address (odd word address 2r+1) clears every bit of register r that is set in the write data. Bits that are zero in the write data keep their stored value.
- R3: A read from either address of a register returns that register's stored value. A read from an unmapped address (6 and above by default) returns zero. A write to an unmapped address changes no register and no output.
- R4: Mask register bit NUM_SRC-1-i enables line source i, so source 0 sits at the most significant stored bit (bit 7 by default).
- R5: Line source i is governed by the FIELD_W-bit field i of the priority registers. Fields run from the top of the first priority register downward: source 0 uses bits [15:12] of register 1, and source 1 uses bits [11:8]. The field after the last line source is the group field for all chain sources, which is bits [15:12] of register 2 by default. A field enables its sources when it is nonzero.
- R6: Line source i is pending exactly when its request input is high, its mask bit is set, and its priority field is nonzero. Pending state follows inputs and register contents with one clock of delay.
- R7: cpuIrq is high exactly when at least one source is pending. vecValid is high exactly when some source is pending and intMask is not 4'hF.
- R8: While vecValid is high, vecOut equals VEC_BASE + VEC_STEP*i, where i is the lowest-numbered pending source (0x200 + 0x20*i by default). While vecValid is low, vecOut is zero.
- R9: The chain position is irlLevel XOR 15. When that position is below CHAIN_LEN, chain source NUM_LINE+position is asserted and all other chain sources are deasserted. The selection stands in for the source's mask bit, so the source is pending exactly when the group field is nonzero. Level 0, and any level whose position is CHAIN_LEN or higher, asserts no chain source.
- R10: After reset, all registers read zero and cpuIrq and vecValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for the register bus |
| busAddr | input | ADDR_W | Word address of the register access |
| busWrData | input | REG_W | Write data |
| busRdData | output | REG_W | Read data for busAddr, combinational |
| irqIn | input | NUM_LINE | Level request inputs of the line sources |
| irlLevel | input | 4 | Encoded level input (0 = none, 15 = highest) |
| intMask | input | 4 | CPU interrupt mask level; 4'hF hides the vector |
| cpuIrq | output | 1 | Interrupt request to the CPU |
| vecValid | output | 1 | vecOut holds a vector |
| vecOut | output | VEC_W | Vector of the lowest-numbered pending source |

## Verification
The bench goes after these cases:

- **Bit order.** It pairs each enable bit with a request from one neighbour source only. A mask decoded least-significant-first would raise the wrong source or none at all.
- **Set and clear writes.** It overlaps them with bits that are already set. An implementation that stores the data plainly, or clears the complement of it, diverges at once on read-back.
- **Chain selection.** Levels 15, 12, 11 and 0 probe both ends of the chain and the positions past it. The group field is then removed while the level is held. Missing the XOR inversion, or forcing the source past its group field, shows up on cpuIrq.
- **Mask level 4'hF.** Driving intMask to 4'hF while requests are pending separates cpuIrq from vecValid.
- **Unmapped writes.** Writes to unmapped addresses, followed by reads of every register, expose decoders that alias the upper addresses.

// File: rtl/setclr_intc_pkg.sv
package setclr_intc_pkg;

  localparam int REG_SEL_W = 3;

  // Decoded bus access, handed from the control to the datapath.
  typedef struct packed {
    logic                 hit;
    logic                 wrSet;
    logic                 wrClr;
    logic [REG_SEL_W-1:0] regSel;
  } busStrobe_t;

endpackage

// File: rtl/setclr_intc_ctrl.sv
module setclr_intc_ctrl
  import setclr_intc_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_REG = 3
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        stb
);

  localparam int MAP_END = 2 * NUM_REG;

  logic [ADDR_W-1:0] wordIdx;

  assign wordIdx = busAddr >> 1;

  // Even address = set port, odd address = clear port of register addr/2.
  always_comb begin
    stb = '0;
    if (busAddr < ADDR_W'(MAP_END)) begin
      stb.hit    = 1'b1;
      stb.regSel = REG_SEL_W'(wordIdx);
      stb.wrSet  = busWrEn && !busAddr[0];
      stb.wrClr  = busWrEn && busAddr[0];
    end
  end

endmodule

// File: rtl/setclr_intc_dp.sv
module setclr_intc_dp
  import setclr_intc_pkg::*;
#(
  parameter int NUM_LINE  = 4,
  parameter int CHAIN_LEN = 4,
  parameter int FIELD_W   = 4,
  parameter int REG_W     = 16,
  parameter int NUM_REG   = 3,
  parameter int VEC_W     = 12,
  parameter int VEC_BASE  = 'h200,
  parameter int VEC_STEP  = 'h20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  busStrobe_t               stb,
  input  logic [REG_W-1:0]         wrData,
  input  logic [NUM_LINE-1:0]      irqIn,
  input  logic [3:0]               irlLevel,
  input  logic [3:0]               intMask,
  output logic [REG_W-1:0]         rdData,
  output logic [NUM_REG*REG_W-1:0] regFlat,
  output logic                     cpuIrq,
  output logic                     vecValid,
  output logic [VEC_W-1:0]         vecOut
);

  localparam int NUM_SRC   = NUM_LINE + CHAIN_LEN;
  localparam int FPR       = REG_W / FIELD_W;
  localparam int NUM_FIELD = NUM_LINE + 1;
  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [REG_W-1:0] MASK_KEEP = REG_W'({NUM_SRC{1'b1}});

  logic [NUM_REG-1:0][REG_W-1:0] regQ;
  logic [NUM_LINE-1:0]  maskBit;
  logic [NUM_FIELD-1:0] prioOn;
  logic [CHAIN_LEN-1:0] chainSel;
  logic [NUM_SRC-1:0]   pendNext;
  logic [NUM_SRC-1:0]   pendQ;
  logic [3:0]           chainPos;
  logic [IDX_W-1:0]     winIdx;

  // Register bank with set/clear write ports.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
    end else begin
      for (int r = 0; r < NUM_REG; r++) begin
        if (stb.regSel == REG_SEL_W'(r)) begin
          if (stb.wrSet)
            regQ[r] <= (regQ[r] | wrData) & ((r == 0) ? MASK_KEEP : {REG_W{1'b1}});
          else if (stb.wrClr)
            regQ[r] <= regQ[r] & ~wrData;
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int r = 0; r < NUM_REG; r++)
      if (stb.hit && stb.regSel == REG_SEL_W'(r)) rdData = regQ[r];
  end

  assign regFlat = regQ;

  // Mask bits: source 0 at the top stored bit.
  for (genvar i = 0; i < NUM_LINE; i++) begin : g_mask
    assign maskBit[i] = regQ[0][NUM_SRC-1-i];
  end

  // Priority fields, top field of each register first; the last one is the group.
  for (genvar f = 0; f < NUM_FIELD; f++) begin : g_field
    localparam int FREG = 1 + f / FPR;
    localparam int FLSB = (FPR - 1 - f % FPR) * FIELD_W;
    assign prioOn[f] = |regQ[FREG][FLSB +: FIELD_W];
  end

  // Encoded level to one-hot chain selection.
  assign chainPos = irlLevel ^ 4'hF;
  for (genvar j = 0; j < CHAIN_LEN; j++) begin : g_chain
    assign chainSel[j]          = (chainPos == 4'(j));
    assign pendNext[NUM_LINE+j] = chainSel[j] && prioOn[NUM_LINE];
  end

  for (genvar i = 0; i < NUM_LINE; i++) begin : g_line
    assign pendNext[i] = irqIn[i] && maskBit[i] && prioOn[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendNext;
  end

  // Lowest-numbered pending source wins.
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pendQ[i]) winIdx = IDX_W'(i);
  end

  assign cpuIrq   = |pendQ;
  assign vecValid = cpuIrq && (intMask != 4'hF);
  assign vecOut   = vecValid ? (VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(winIdx)) : '0;

endmodule

// File: rtl/setclr_intc.sv
module setclr_intc
  import setclr_intc_pkg::*;
#(
  parameter int NUM_LINE  = 4,
  parameter int CHAIN_LEN = 4,
  parameter int FIELD_W   = 4,
  parameter int REG_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int VEC_W     = 12,
  parameter int VEC_BASE  = 'h200,
  parameter int VEC_STEP  = 'h20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [REG_W-1:0]    busWrData,
  output logic [REG_W-1:0]    busRdData,
  input  logic [NUM_LINE-1:0] irqIn,
  input  logic [3:0]          irlLevel,
  input  logic [3:0]          intMask,
  output logic                cpuIrq,
  output logic                vecValid,
  output logic [VEC_W-1:0]    vecOut
);

  localparam int FPR          = REG_W / FIELD_W;
  localparam int NUM_PRIO_REG = (NUM_LINE + 1 + FPR - 1) / FPR;
  localparam int NUM_REG      = 1 + NUM_PRIO_REG;

  busStrobe_t               stb;
  logic [NUM_REG*REG_W-1:0] regFlat;

  setclr_intc_ctrl #(
    .ADDR_W (ADDR_W),
    .NUM_REG(NUM_REG)
  ) ctrl_i (
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .stb    (stb)
  );

  setclr_intc_dp #(
    .NUM_LINE (NUM_LINE),
    .CHAIN_LEN(CHAIN_LEN),
    .FIELD_W  (FIELD_W),
    .REG_W    (REG_W),
    .NUM_REG  (NUM_REG),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (busWrData),
    .irqIn   (irqIn),
    .irlLevel(irlLevel),
    .intMask (intMask),
    .rdData  (busRdData),
    .regFlat (regFlat),
    .cpuIrq  (cpuIrq),
    .vecValid(vecValid),
    .vecOut  (vecOut)
  );

endmodule

// File: rtl/setclr_intc_chk.sv
module setclr_intc_chk #(
  parameter int NUM_LINE = 4,
  parameter int FIELD_W  = 4,
  parameter int REG_W    = 16,
  parameter int ADDR_W   = 4,
  parameter int NUM_REG  = 3,
  parameter int VEC_W    = 12
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     busWrEn,
  input logic [ADDR_W-1:0]        busAddr,
  input logic [REG_W-1:0]         busWrData,
  input logic [3:0]               irlLevel,
  input logic [3:0]               intMask,
  input logic [NUM_REG*REG_W-1:0] regFlat,
  input logic                     cpuIrq,
  input logic                     vecValid,
  input logic [VEC_W-1:0]         vecOut
);

  localparam int FPR      = REG_W / FIELD_W;
  localparam int MAP_END  = 2 * NUM_REG;
  localparam int GRP_BIT  = (1 + NUM_LINE / FPR) * REG_W + (FPR - 1 - NUM_LINE % FPR) * FIELD_W;

  logic [REG_W-1:0] prioA;
  logic             groupOn;

  assign prioA   = regFlat[REG_W +: REG_W];
  assign groupOn = |regFlat[GRP_BIT +: FIELD_W];

  p_set_or_r1: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == ADDR_W'(2) |=> prioA == ($past(prioA) | $past(busWrData)));

  p_clr_andn_r2: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == ADDR_W'(3) |=> prioA == ($past(prioA) & ~$past(busWrData)));

  p_unmapped_r3: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr >= ADDR_W'(MAP_END) |=> $stable(regFlat));

  p_valid_cond_r7: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> cpuIrq && intMask != 4'hF);

  p_valid_given_r7: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq && intMask != 4'hF |-> vecValid);

  p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !vecValid |-> vecOut == '0);

  p_level_top_r9: assert property (@(posedge clk) disable iff (!rstN)
    irlLevel == 4'hF && groupOn |=> cpuIrq);

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rstN |=> !cpuIrq && !vecValid);

endmodule

bind setclr_intc setclr_intc_chk #(
  .NUM_LINE(NUM_LINE),
  .FIELD_W (FIELD_W),
  .REG_W   (REG_W),
  .ADDR_W  (ADDR_W),
  .NUM_REG (NUM_REG),
  .VEC_W   (VEC_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .irlLevel (irlLevel),
  .intMask  (intMask),
  .regFlat  (regFlat),
  .cpuIrq   (cpuIrq),
  .vecValid (vecValid),
  .vecOut   (vecOut)
);

// File: tb/setclr_intc_tb_top.sv
`timescale 1ns/1ps
module setclr_intc_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [3:0]  irqIn = '0;
  logic [3:0]  irlLevel = '0;
  logic [3:0]  intMask = '0;
  logic        cpuIrq;
  logic        vecValid;
  logic [11:0] vecOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] mreg [3];

  always #4 clk = ~clk;

  setclr_intc dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqIn(irqIn),
    .irlLevel(irlLevel), .intMask(intMask), .cpuIrq(cpuIrq),
    .vecValid(vecValid), .vecOut(vecOut)
  );

  function automatic logic [7:0] expPend();
    logic [7:0] p;
    logic grp;
    grp = |mreg[2][15:12];
    for (int i = 0; i < 4; i++)
      p[i] = irqIn[i] && mreg[0][7-i] && (|mreg[1][15-4*i -: 4]);
    for (int j = 0; j < 4; j++)
      p[4+j] = ((irlLevel ^ 4'hF) == 4'(j)) && grp;
    return p;
  endfunction

  function automatic logic [11:0] expVec(logic [7:0] p);
    for (int i = 0; i < 8; i++)
      if (p[i]) return 12'h200 + 12'(32 * i);
    return 12'h000;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
    if (a < 4'd6) begin
      if (!a[0]) mreg[a >> 1] = (mreg[a >> 1] | d) & ((a >> 1) == 0 ? 16'h00FF : 16'hFFFF);
      else       mreg[a >> 1] = mreg[a >> 1] & ~d;
    end
  endtask

  task automatic rdCheck(string tag, logic [3:0] a);
    busAddr = a;
    #1;
    check(tag, 32'(busRdData), (a < 4'd6) ? 32'(mreg[a >> 1]) : 32'h0);
  endtask

  // One clock for pending state to follow, then compare all outputs.
  task automatic outCheck(string tag);
    logic [7:0] p;
    @(negedge clk);
    p = expPend();
    check(tag, 32'(cpuIrq), 32'(|p));
    check(tag, 32'(vecValid), 32'((|p) && intMask != 4'hF));
    check(tag, 32'(vecOut), ((|p) && intMask != 4'hF) ? 32'(expVec(p)) : 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    for (int r = 0; r < 3; r++) mreg[r] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 cpuIrq", 32'(cpuIrq), 32'h0);
    check("R10 vecValid", 32'(vecValid), 32'h0);
    for (int a = 0; a < 6; a++) rdCheck("R10 read", 4'(a));
    rstN = 1'b1;
    @(negedge clk);

    // R1: set writes OR, upper mask bits dropped
    wr(4'd0, 16'hFFF0);
    rdCheck("R1 mask set", 4'd0);
    wr(4'd0, 16'h0030);
    rdCheck("R1 mask or", 4'd0);
    rdCheck("R3 read via clear addr", 4'd1);
    // R2: clear writes
    wr(4'd1, 16'h0050);
    rdCheck("R2 mask clr", 4'd0);
    check("R2 mask value", 32'(busRdData), 32'h00A0);

    // R6/R8: source 0 fully enabled
    wr(4'd2, 16'h1100);
    irqIn = 4'b0001;
    outCheck("R6 src0");
    check("R8 src0 vec", 32'(vecOut), 32'h200);
    // R4: src1 has field but mask bit 6 clear
    irqIn = 4'b0010;
    outCheck("R4 src1 masked");
    check("R4 src1 off", 32'(cpuIrq), 32'h0);
    wr(4'd0, 16'h0040);
    outCheck("R4 src1 bit6");
    check("R4 src1 vec", 32'(vecOut), 32'h220);
    // R5: priority field zero blocks, nonzero value enables
    irqIn = 4'b0011;
    wr(4'd3, 16'hF000);
    outCheck("R5 field zero");
    check("R5 src1 wins", 32'(vecOut), 32'h220);
    wr(4'd2, 16'h8000);
    outCheck("R5 field nonzero");
    check("R8 lowest wins", 32'(vecOut), 32'h200);
    // R7: mask level F hides vector
    intMask = 4'hF;
    outCheck("R7 imask F");
    check("R7 irq still high", 32'(cpuIrq), 32'h1);
    intMask = 4'h3;
    // R3: unmapped writes
    wr(4'd6, 16'hFFFF);
    wr(4'd15, 16'hFFFF);
    for (int a = 0; a < 8; a++) rdCheck("R3 unmapped", 4'(a));
    outCheck("R3 outputs");

    // R9: level chain
    irqIn = 4'b0000;
    wr(4'd4, 16'h1000);
    wr(4'd1, 16'h000F);
    irlLevel = 4'd15;
    outCheck("R9 level15");
    check("R9 level15 vec", 32'(vecOut), 32'h280);
    irlLevel = 4'd12;
    outCheck("R9 level12");
    check("R9 level12 vec", 32'(vecOut), 32'h2E0);
    irlLevel = 4'd11;
    outCheck("R9 level11");
    check("R9 level11 none", 32'(cpuIrq), 32'h0);
    irlLevel = 4'd0;
    outCheck("R9 level0");
    irlLevel = 4'd15;
    wr(4'd5, 16'hF000);
    outCheck("R9 group off");
    check("R9 group off none", 32'(cpuIrq), 32'h0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 4);
      case (op)
        0, 1: wr(4'($urandom_range(0, 7)), 16'($urandom));
        2: begin @(negedge clk); irqIn = 4'($urandom); end
        3: begin @(negedge clk); irlLevel = 4'($urandom_range(10, 15)); end
        default: begin @(negedge clk); intMask = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom); end
      endcase
      outCheck("R6 random");
      rdCheck("R3 random", 4'($urandom_range(0, 7)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule